// File: doc/BRIEF.md
# Frame Link Integrity Monitor

This block sits behind the deserializer of a converter link and decides whether the frames it delivers can be trusted. Each frame carries a payload, an 8-bit sequence number and an 8-bit check byte. The monitor recomputes the check byte one byte per clock and compares it with the received one. It tracks the expected sequence number and watches the time since the last trusted frame. Only frames that pass every test are passed on to downstream logic.

Bad frames are counted, and the sequence number and arrival timestamp of the most recent failure are kept. A bad check byte does not raise the fault output on its own. The fault is raised when the number of check-byte failures among the most recent N completed frames goes above a configured limit. A short burst is absorbed, while a steady stream of errors trips the fault. The fault output holds until software pulses a clear, and the clear also empties the error window.

Top module: `frame_link_guard`

## Requirements
- R1: The check byte is a CRC-8 with polynomial 0x07, initial value 0x00, no reflection and no final XOR. It is computed MSB first over the payload bytes, least significant byte first, and then over the sequence byte. If it differs from `frm_crc`, the frame is a CRC failure: `cnt_crc_err` increments and the frame is not forwarded.
- R2: A frame is captured on a clock edge where `frm_valid` is high and the checker is idle. Its outcome becomes visible on the outputs PB+2 edges later. A `frm_valid` arriving in the PB+1 edges after a capture is dropped and has no effect at all.
- R3: A frame with a good CRC, received while synchronised, whose sequence number equals the previous one plus 1 modulo 256 (255 is followed by 0) is forwarded. `out_valid` pulses for one cycle, with `out_payload` and `out_seq` holding that frame's fields.
- R4: A frame with a good CRC, received while synchronised, whose sequence number is not the expected one increments `cnt_seq_err` and is not forwarded. The next expected number becomes its sequence number plus 1.
- R5: After reset, and after a timeout, the monitor is unsynchronised. The next frame with a good CRC is rejected as stale without touching any counter. It sets the expected number to its sequence number plus 1 and makes the monitor synchronised again.
- R6: When `cfg_fresh` (non-zero) consecutive edges pass without a forwarded or stale-resync frame, `cnt_timeout` increments, the monitor becomes unsynchronised and the freshness timer restarts. A value of 0 in `cfg_fresh` disables the timeout.
- R7: Every completed frame enters an error window of the last `cfg_win` frames (1..WIN_MAX). `link_fault` sets when the number of CRC failures in that window exceeds `cfg_limit`, so a burst of at most `cfg_limit` failures never trips it.
- R8: Persistent CRC failures set `link_fault`. Once set, it stays set until a `fault_clr` pulse. That pulse clears the fault and empties the error window on the same edge, and leaves the event counters unchanged.
- R9: On a CRC or sequence failure, `bad_seq` takes the frame's sequence field and `bad_ts` takes the `frm_ts` value sampled on its capture edge.
- R10: The event counters saturate at all ones and never decrease except through reset.
- R11: Reset (synchronous, active high) zeroes all counters, `bad_seq`, `bad_ts`, `out_valid` and `link_fault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_valid | input | 1 | Frame present this cycle |
| frm_payload | input | PB*8 | Frame payload |
| frm_seq | input | 8 | Frame sequence number |
| frm_crc | input | 8 | Received check byte |
| frm_ts | input | TS_W | Timestamp sampled with the frame |
| cfg_win | input | clog2(WIN_MAX+1) | Error window length in frames |
| cfg_limit | input | clog2(WIN_MAX+1) | Error count that must be exceeded to fault |
| cfg_fresh | input | TMO_W | Freshness window in cycles, 0 disables |
| fault_clr | input | 1 | Clear pulse for fault and error window |
| out_valid | output | 1 | Forwarded frame pulse |
| out_payload | output | PB*8 | Payload of the last forwarded frame |
| out_seq | output | 8 | Sequence number of the last forwarded frame |
| link_fault | output | 1 | Sticky link fault |
| cnt_crc_err | output | CNT_W | CRC failure count |
| cnt_seq_err | output | CNT_W | Sequence failure count |
| cnt_timeout | output | CNT_W | Timeout count |
| bad_seq | output | 8 | Sequence field of the last failing frame |
| bad_ts | output | TS_W | Timestamp of the last failing frame |

## Verification
The embedded properties assume that `cfg_win` and `cfg_limit` stay fixed between clears, since the running window count is only correct for a fixed length. They also assume that `fault_clr` is not pulsed on an edge where a frame outcome is being decided. The stimulus programs the configuration once after reset, spaces frames at least PB+2 edges apart except in the deliberate overlap case, and pulses the clear only after the pipeline has drained. Timeouts are provoked by idle gaps and by runs of rejected frames, and the behavioural model tracks them in parallel.

// File: rtl/flg_pkg.sv
package flg_pkg;

  // Outcome of one completed frame.
  typedef enum logic [2:0] {
    VD_NONE  = 3'd0,
    VD_FWD   = 3'd1,
    VD_CRC   = 3'd2,
    VD_SEQ   = 3'd3,
    VD_STALE = 3'd4
  } verdict_t;

  localparam logic [7:0] CRC_POLY = 8'h07;

  // One byte of CRC-8, MSB first, non-reflected.
  function automatic logic [7:0] crc8_byte(input logic [7:0] acc, input logic [7:0] data);
    logic [7:0] r;
    r = acc ^ data;
    for (int i = 0; i < 8; i++) begin
      r = r[7] ? ((r << 1) ^ CRC_POLY) : (r << 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/flg_crc_engine.sv
module flg_crc_engine
  import flg_pkg::*;
#(
  parameter int PB   = 4,
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [PB*8-1:0] payload,
  input  logic [7:0]      seq,
  input  logic [7:0]      crc_rx,
  input  logic [TS_W-1:0] ts,
  output logic            done,
  output logic            crc_ok,
  output logic [PB*8-1:0] h_payload,
  output logic [7:0]      h_seq,
  output logic [TS_W-1:0] h_ts
);
  localparam int NB = PB + 1;          // payload bytes plus sequence byte
  localparam int IW = $clog2(NB);

  logic [NB*8-1:0] sh;
  logic [IW-1:0]   idx;
  logic [7:0]      acc;
  logic [7:0]      crc_q;
  logic            busy;

  // Frame is held while the byte-serial CRC walks through it.
  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      idx       <= '0;
      acc       <= '0;
      sh        <= '0;
      crc_q     <= '0;
      h_payload <= '0;
      h_seq     <= '0;
      h_ts      <= '0;
    end else begin
      done <= 1'b0;
      if (!busy && start) begin
        busy      <= 1'b1;
        idx       <= '0;
        acc       <= '0;
        sh        <= {seq, payload};
        crc_q     <= crc_rx;
        h_payload <= payload;
        h_seq     <= seq;
        h_ts      <= ts;
      end else if (busy) begin
        acc <= crc8_byte(acc, sh[7:0]);
        sh  <= sh >> 8;
        idx <= idx + 1'b1;
        if (idx == IW'(NB - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign crc_ok = (acc == crc_q);

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy)) else $error("done without a busy run"); // R2

  AST_BUSY_DROPS_START: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(h_seq)) else $error("frame taken while busy"); // R2

endmodule

// File: rtl/flg_rate_window.sv
module flg_rate_window #(
  parameter int WIN_MAX = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clr,
  input  logic                         push,
  input  logic                         err,
  input  logic [$clog2(WIN_MAX+1)-1:0] win_len,
  input  logic [$clog2(WIN_MAX+1)-1:0] limit,
  output logic                         over
);
  localparam int WW = $clog2(WIN_MAX + 1);
  localparam int PW = $clog2(WIN_MAX);

  logic [WIN_MAX-1:0] hist;     // bit 0 is the newest frame
  logic [WW-1:0]      cnt;
  logic [WW-1:0]      cnt_nxt;
  logic [WW-1:0]      len_c;
  logic [PW-1:0]      pos;
  logic               leave;

  always_comb begin
    if (win_len == '0)                 len_c = WW'(1);
    else if (win_len > WW'(WIN_MAX))   len_c = WW'(WIN_MAX);
    else                               len_c = win_len;
    pos     = PW'(len_c - 1'b1);
    leave   = hist[pos];
    cnt_nxt = cnt + WW'(err) - WW'(leave);
    over    = push && !clr && (cnt_nxt > limit);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      hist <= '0;
      cnt  <= '0;
    end else if (push) begin
      hist <= {hist[WIN_MAX-2:0], err};
      cnt  <= cnt_nxt;
    end
  end

  AST_WIN_CLEARED: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0)) else $error("window not emptied by clear"); // R8

  AST_WIN_STEP: assert property (@(posedge clk) disable iff (rst)
    (push && !clr) |=> (cnt <= $past(cnt) + 1'b1)) else $error("window count jumped"); // R7

endmodule

// File: rtl/flg_fresh_timer.sv
module flg_fresh_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          refresh,
  input  logic [TW-1:0] limit,
  output logic          expire
);
  logic [TW-1:0] cnt;

  assign expire = !refresh && (limit != '0) && (cnt == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (rst)                    cnt <= '0;
    else if (refresh || expire) cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end

  AST_TMO_RESTART: assert property (@(posedge clk) disable iff (rst)
    expire |=> (cnt == '0)) else $error("timer did not restart"); // R6

endmodule

// File: rtl/flg_sat_counter.sv
module flg_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] value
);
  always_ff @(posedge clk) begin
    if (rst)                      value <= '0;
    else if (inc && value != '1)  value <= value + 1'b1;
  end

  AST_CNT_HOLD_TOP: assert property (@(posedge clk) disable iff (rst)
    (inc && value == '1) |=> (value == '1)) else $error("counter wrapped"); // R10

  AST_CNT_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(value)) else $error("counter moved without event"); // R10

endmodule

// File: rtl/frame_link_guard.sv
module frame_link_guard
  import flg_pkg::*;
#(
  parameter int PB      = 4,
  parameter int TS_W    = 32,
  parameter int CNT_W   = 16,
  parameter int WIN_MAX = 16,
  parameter int TMO_W   = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         frm_valid,
  input  logic [PB*8-1:0]              frm_payload,
  input  logic [7:0]                   frm_seq,
  input  logic [7:0]                   frm_crc,
  input  logic [TS_W-1:0]              frm_ts,
  input  logic [$clog2(WIN_MAX+1)-1:0] cfg_win,
  input  logic [$clog2(WIN_MAX+1)-1:0] cfg_limit,
  input  logic [TMO_W-1:0]             cfg_fresh,
  input  logic                         fault_clr,
  output logic                         out_valid,
  output logic [PB*8-1:0]              out_payload,
  output logic [7:0]                   out_seq,
  output logic                         link_fault,
  output logic [CNT_W-1:0]             cnt_crc_err,
  output logic [CNT_W-1:0]             cnt_seq_err,
  output logic [CNT_W-1:0]             cnt_timeout,
  output logic [7:0]                   bad_seq,
  output logic [TS_W-1:0]              bad_ts
);
  localparam int N_EVT = 3;   // crc, sequence, timeout

  logic            eng_done;
  logic            eng_ok;
  logic [PB*8-1:0] h_pay;
  logic [7:0]      h_seq;
  logic [TS_W-1:0] h_ts;

  flg_crc_engine #(.PB(PB), .TS_W(TS_W)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .start     (frm_valid),
    .payload   (frm_payload),
    .seq       (frm_seq),
    .crc_rx    (frm_crc),
    .ts        (frm_ts),
    .done      (eng_done),
    .crc_ok    (eng_ok),
    .h_payload (h_pay),
    .h_seq     (h_seq),
    .h_ts      (h_ts)
  );

  logic       synced;
  logic [7:0] exp_seq;
  verdict_t   vd;

  // Checks in priority order: integrity, then freshness state, then order.
  always_comb begin
    vd = VD_NONE;
    if (eng_done) begin
      if (!eng_ok)                vd = VD_CRC;
      else if (!synced)           vd = VD_STALE;
      else if (h_seq != exp_seq)  vd = VD_SEQ;
      else                        vd = VD_FWD;
    end
  end

  logic refresh;
  logic expire;
  logic win_over;

  assign refresh = (vd == VD_FWD) || (vd == VD_STALE);

  flg_fresh_timer #(.TW(TMO_W)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .refresh (refresh),
    .limit   (cfg_fresh),
    .expire  (expire)
  );

  flg_rate_window #(.WIN_MAX(WIN_MAX)) u_win (
    .clk     (clk),
    .rst     (rst),
    .clr     (fault_clr),
    .push    (eng_done),
    .err     (vd == VD_CRC),
    .win_len (cfg_win),
    .limit   (cfg_limit),
    .over    (win_over)
  );

  logic [N_EVT-1:0] evt;
  logic [CNT_W-1:0] evt_cnt [N_EVT];

  assign evt = {expire, (vd == VD_SEQ), (vd == VD_CRC)};

  generate
    for (genvar g = 0; g < N_EVT; g++) begin : g_evt
      flg_sat_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .inc   (evt[g]),
        .value (evt_cnt[g])
      );
    end
  endgenerate

  assign cnt_crc_err = evt_cnt[0];
  assign cnt_seq_err = evt_cnt[1];
  assign cnt_timeout = evt_cnt[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      synced      <= 1'b0;
      exp_seq     <= '0;
      out_valid   <= 1'b0;
      out_payload <= '0;
      out_seq     <= '0;
      bad_seq     <= '0;
      bad_ts      <= '0;
      link_fault  <= 1'b0;
    end else begin
      out_valid <= (vd == VD_FWD);
      if (vd == VD_FWD) begin
        out_payload <= h_pay;
        out_seq     <= h_seq;
      end
      if (vd inside {VD_FWD, VD_SEQ, VD_STALE}) exp_seq <= h_seq + 8'd1;
      if (expire)               synced <= 1'b0;
      else if (vd == VD_STALE)  synced <= 1'b1;
      if (vd == VD_CRC || vd == VD_SEQ) begin
        bad_seq <= h_seq;
        bad_ts  <= h_ts;
      end
      if (fault_clr)     link_fault <= 1'b0;
      else if (win_over) link_fault <= 1'b1;
    end
  end

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
    (link_fault && !fault_clr) |=> link_fault) else $error("fault dropped without clear"); // R8

  AST_OUT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid) else $error("forward pulse too long"); // R3

endmodule

// File: tb/frame_link_guard_test.sv
module frame_link_guard_test;
  localparam int CLK_PERIOD = 10;
  localparam int PB      = 4;
  localparam int NB      = PB + 1;
  localparam int TS_W    = 16;
  localparam int CNT_W   = 4;
  localparam int WIN_MAX = 8;
  localparam int TMO_W   = 8;
  localparam int WW      = $clog2(WIN_MAX + 1);
  localparam int CMAX    = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic            frm_valid = 1'b0;
  logic [PB*8-1:0] frm_payload = '0;
  logic [7:0]      frm_seq = '0;
  logic [7:0]      frm_crc = '0;
  logic [TS_W-1:0] frm_ts = '0;
  logic [WW-1:0]   cfg_win = WW'(4);
  logic [WW-1:0]   cfg_limit = WW'(2);
  logic [TMO_W-1:0] cfg_fresh = TMO_W'(40);
  logic            fault_clr = 1'b0;

  logic            out_valid;
  logic [PB*8-1:0] out_payload;
  logic [7:0]      out_seq;
  logic            link_fault;
  logic [CNT_W-1:0] cnt_crc_err, cnt_seq_err, cnt_timeout;
  logic [7:0]      bad_seq;
  logic [TS_W-1:0] bad_ts;

  frame_link_guard #(.PB(PB), .TS_W(TS_W), .CNT_W(CNT_W), .WIN_MAX(WIN_MAX), .TMO_W(TMO_W)) uut (
    .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_payload(frm_payload),
    .frm_seq(frm_seq), .frm_crc(frm_crc), .frm_ts(frm_ts), .cfg_win(cfg_win),
    .cfg_limit(cfg_limit), .cfg_fresh(cfg_fresh), .fault_clr(fault_clr),
    .out_valid(out_valid), .out_payload(out_payload), .out_seq(out_seq),
    .link_fault(link_fault), .cnt_crc_err(cnt_crc_err), .cnt_seq_err(cnt_seq_err),
    .cnt_timeout(cnt_timeout), .bad_seq(bad_seq), .bad_ts(bad_ts)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int n_fwd = 0;
  int wd    = 0;
  bit checking = 1'b0;

  task automatic chk(input string tag, input longint unsigned got, input longint unsigned exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // Bit-serial CRC over the byte stream (R1 ordering).
  function automatic logic [7:0] ref_crc(input logic [PB*8-1:0] p, input logic [7:0] s);
    logic [7:0] c;
    logic [NB*8-1:0] st;
    c  = 8'h00;
    st = {s, p};
    for (int k = 0; k < NB; k++) begin
      for (int b = 7; b >= 0; b--) begin
        logic fb;
        fb = c[7] ^ st[8*k + b];
        c  = {c[6:0], 1'b0};
        if (fb) c = c ^ 8'h07;
      end
    end
    return c;
  endfunction

  // ---------------- behavioural reference model ----------------
  int              ecount, m_due, m_free, m_fresh, vd, errs;
  bit              m_pend, m_synced, expire;
  logic [PB*8-1:0] m_pay;
  logic [7:0]      m_seq, m_crc, m_exp;
  logic [TS_W-1:0] m_ts;
  int              win_q[$];
  bit              x_valid, x_fault;
  logic [PB*8-1:0] x_pay;
  logic [7:0]      x_seq, x_bad_seq;
  logic [TS_W-1:0] x_bad_ts;
  int              x_cnt[3];

  always @(posedge clk) begin
    if (rst) begin
      ecount = 0; m_due = 0; m_free = 0; m_fresh = 0; m_pend = 0;
      m_synced = 0; m_exp = 0; win_q.delete();
      x_valid = 0; x_fault = 0; x_pay = '0; x_seq = '0;
      x_bad_seq = '0; x_bad_ts = '0;
      for (int i = 0; i < 3; i++) x_cnt[i] = 0;
    end else begin
      vd = 0;
      if (m_pend && m_due == ecount) begin
        m_pend = 0;
        if (ref_crc(m_pay, m_seq) != m_crc) vd = 2;
        else if (!m_synced)                 vd = 4;
        else if (m_seq != m_exp)            vd = 3;
        else                                vd = 1;
      end
      expire = 0;
      if (vd == 1 || vd == 4) m_fresh = 0;
      else if (cfg_fresh != 0) begin
        m_fresh++;
        if (m_fresh == int'(cfg_fresh)) begin expire = 1; m_fresh = 0; end
      end
      x_valid = (vd == 1);
      if (vd == 1) begin x_pay = m_pay; x_seq = m_seq; end
      if (vd == 1 || vd == 3 || vd == 4) m_exp = m_seq + 8'd1;
      if (expire) m_synced = 0; else if (vd == 4) m_synced = 1;
      if (vd == 2 || vd == 3) begin x_bad_seq = m_seq; x_bad_ts = m_ts; end
      if (vd == 2 && x_cnt[0] < CMAX) x_cnt[0]++;
      if (vd == 3 && x_cnt[1] < CMAX) x_cnt[1]++;
      if (expire  && x_cnt[2] < CMAX) x_cnt[2]++;
      if (fault_clr) begin
        win_q.delete();
        x_fault = 0;
      end else if (vd != 0) begin
        win_q.push_front(vd == 2 ? 1 : 0);
        if (win_q.size() > WIN_MAX) void'(win_q.pop_back());
        errs = 0;
        for (int k = 0; k < win_q.size() && k < int'(cfg_win); k++) errs += win_q[k];
        if (errs > int'(cfg_limit)) x_fault = 1;
      end
      if (frm_valid && ecount >= m_free) begin
        m_pend = 1; m_due = ecount + NB + 1; m_free = ecount + NB + 1;
        m_pay = frm_payload; m_seq = frm_seq; m_crc = frm_crc; m_ts = frm_ts;
      end
      ecount++;
    end
  end

  // Cycle-by-cycle comparison away from the active edge.
  always @(negedge clk) begin
    if (checking && !rst) begin
      chk("R3 out_valid", out_valid, x_valid);
      if (x_valid) begin
        chk("R3 out_payload", out_payload, x_pay);
        chk("R3 out_seq", out_seq, x_seq);
        n_fwd++;
      end
      chk("R7 link_fault", link_fault, x_fault);
      chk("R1 cnt_crc_err", cnt_crc_err, x_cnt[0]);
      chk("R4 cnt_seq_err", cnt_seq_err, x_cnt[1]);
      chk("R6 cnt_timeout", cnt_timeout, x_cnt[2]);
      chk("R9 bad_seq", bad_seq, x_bad_seq);
      chk("R9 bad_ts", bad_ts, x_bad_ts);
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      n_bad++;
      $display("FAIL R2 watchdog actual=%0d cycles expected=<20000", wd);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  logic [TS_W-1:0] ts_k = 16'h0100;

  task automatic send(input logic [7:0] s, input bit corrupt, input int gap);
    @(posedge clk); #2;
    frm_valid   = 1'b1;
    frm_seq     = s;
    frm_payload = {s, ~s, s ^ 8'h5a, ts_k[7:0]};
    frm_crc     = ref_crc({s, ~s, s ^ 8'h5a, ts_k[7:0]}, s) ^ (corrupt ? 8'h01 : 8'h00);
    frm_ts      = ts_k;
    ts_k        = ts_k + 16'd13;
    @(posedge clk); #2;
    frm_valid = 1'b0;
    repeat (gap - 1) @(posedge clk);
  endtask

  task automatic settle();
    repeat (8) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 link_fault", link_fault, 0);
    chk("R11 out_valid", out_valid, 0);
    chk("R11 cnt_crc_err", cnt_crc_err, 0);
    chk("R11 cnt_seq_err", cnt_seq_err, 0);
    chk("R11 cnt_timeout", cnt_timeout, 0);
    chk("R11 bad_ts", bad_ts, 0);
    checking = 1'b1;

    send(8'd10, 0, 5); settle();
    chk("R5 first frame after reset not forwarded", n_fwd, 0);

    for (int s = 11; s <= 14; s++) send(8'(s), 0, 5);
    settle();
    chk("R3 in-order frames forwarded", n_fwd, 4);

    send(8'd20, 0, 5); send(8'd21, 0, 5); settle();
    chk("R4 gap in sequence counted", cnt_seq_err, 1);
    chk("R9 failing sequence recorded", bad_seq, 20);

    send(8'd254, 0, 5);
    send(8'd255, 0, 5); send(8'd0, 0, 5); send(8'd1, 0, 5); settle();
    chk("R3 wrap from 255 to 0", n_fwd, 8);

    send(8'd2, 1, 5); send(8'd2, 1, 5);
    for (int s = 2; s <= 5; s++) send(8'(s), 0, 5);
    settle();
    chk("R7 isolated burst does not trip", link_fault, 0);
    chk("R1 crc failures counted", cnt_crc_err, 2);

    repeat (50) @(posedge clk);
    @(negedge clk);
    chk("R6 idle link times out", cnt_timeout, 1);
    send(8'd6, 0, 5); send(8'd7, 0, 5); settle();
    chk("R6 first frame after timeout is stale", n_fwd, 13);

    send(8'd8, 0, 2); send(8'd9, 0, 5); send(8'd9, 0, 5); settle();
    chk("R2 overlapping frame dropped", n_fwd, 15);
    chk("R2 dropped frame left sequence intact", cnt_seq_err, 2);

    for (int i = 0; i < 20; i++) send(8'(40 + i), 1, 5);
    settle();
    chk("R8 persistent errors raise fault", link_fault, 1);
    chk("R10 crc counter saturates", cnt_crc_err, CMAX);

    for (int s = 30; s <= 33; s++) send(8'(s), 0, 5);
    settle();
    chk("R8 fault sticky after good frames", link_fault, 1);

    send(8'd70, 1, 5); send(8'd71, 1, 5); settle();
    @(posedge clk); #2 fault_clr = 1'b1;
    @(posedge clk); #2 fault_clr = 1'b0;
    @(negedge clk);
    chk("R8 clear drops fault", link_fault, 0);

    send(8'd72, 1, 5); send(8'd34, 0, 5); send(8'd35, 0, 5); settle();
    chk("R8 clear emptied error window", link_fault, 0);

    repeat (4) @(posedge clk);
    @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule